// File: doc/BRIEF.md
# Configuration download sequencer

This block loads a byte-wide configuration image into an SRAM-based programmable device through its parallel slave port. Image bytes arrive on a valid/ready stream, with a flag on the final byte. Each accepted byte goes onto the configuration data bus, and the write strobe is pulsed low once per byte. Every strobe pulse is also the device's configuration clock. Because the device forgets its image whenever it loses power, the host raises `start` after every power-up or resume, and each `start` begins a complete reload from byte zero.

Two device pins are shared between loading and normal operation. During loading, one line shows the device's completion flag. The other line is ignored. The completion flag can rise some time after the last byte, because the device waits for its internal clock managers to lock. Once completion is seen, the two lines take on their normal roles: the first becomes an active-low interrupt and the second becomes a DMA request. If completion does not arrive within a programmed number of cycles, the block stops in an error state and leaves both run-time paths gated off.

The sequencer has seven states:
- ST_IDLE: waiting for the first request.
- ST_FETCH: offering `s_ready`.
- ST_STROBE: strobe held low.
- ST_GAP: strobe held high.
- ST_WAIT: waiting for completion.
- ST_DONE: load finished.
- ST_ERROR: completion timed out.

Transitions:
- start: ST_IDLE, ST_DONE or ST_ERROR go to ST_FETCH.
- accept: ST_FETCH goes to ST_STROBE.
- low_end: ST_STROBE goes to ST_GAP.
- next_byte: ST_GAP goes to ST_FETCH.
- last_byte: ST_GAP goes to ST_WAIT.
- seen_done: ST_WAIT goes to ST_DONE.
- timeout: ST_WAIT goes to ST_ERROR.

Top module: `cfg_loader`

## Requirements
- R1: While reset is asserted and right after it, the status code is 0, `cfg_wr_n` is 1, `s_ready` is 0, the byte count is 0, `load_err` is 0, and both run-time outputs are 0.
- R2: A `start` pulse seen in idle, done or error enters the loading phase and clears the byte count to 0 in the next cycle.
- R3: `s_ready` is 1 only while the sequencer is waiting for a byte. Each cycle with `s_valid` and `s_ready` both high accepts one byte, places it on `cfg_d` and adds one to the byte count.
- R4: The cycle after a byte is accepted, `cfg_wr_n` goes low. It stays low for exactly STRB_LOW cycles, and `cfg_d` holds the accepted byte throughout.
- R5: Between two strobe pulses, `cfg_wr_n` stays high for at least STRB_HIGH+1 cycles.
- R6: After the strobe high time of the byte marked `s_last`, the block waits for completion. Completion is `done_irq_n` high, seen through SYNC_STAGES flip-flops. When it is seen, the block moves to done. A high level on this line while bytes are still being written does not end the load.
- R7: If completion has not been seen within DONE_WAIT cycles of waiting, the block enters error and `load_err` goes to 1. It stays there until the next `start`.
- R8: Outside done, `run_irq` and `run_dreq` are 0. In done, `run_irq` is the inverse of the synchronized `done_irq_n`, and `run_dreq` is the synchronized `dreq_line`.
- R9: A `start` pulse while bytes are being loaded or while waiting for completion has no effect on state or byte count.
- R10: `stat_code` encodes the phase as follows: 0 for idle, 1 for loading (fetch, strobe or gap), 2 for waiting for completion, 3 for done, and 4 for error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load request, raised on every power-up or resume |
| s_data | input | DW | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Sequencer can take a byte |
| cfg_d | output | DW | Configuration data bus |
| cfg_wr_n | output | 1 | Active-low write strobe, also the configuration clock |
| done_irq_n | input | 1 | Shared line: completion flag during load, active-low interrupt after |
| dreq_line | input | 1 | Shared line: DMA request after the load |
| run_irq | output | 1 | Gated interrupt request, active high |
| run_dreq | output | 1 | Gated DMA request |
| stat_code | output | 3 | Phase code |
| stat_count | output | CNT_W | Bytes accepted in the current load |
| load_err | output | 1 | Completion timeout flag |

## Verification
The strobe-width properties rely on STRB_LOW being at least 1. The low-hold check is only generated when STRB_LOW is 2 or more. The shared lines are treated as asynchronous, so properties involving them are written against the synchronized copies and not the raw pins. The stimulus changes inputs shortly after a clock edge. It raises `s_last` only on the final byte of each image, and it pulses `start` in the middle of loading and while waiting so that the ignore rule is exercised. It also drives the completion line high both before and after the last byte, and it leaves the line low for a whole load so that the timeout path is taken.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STROBE,
        ST_GAP,
        ST_WAIT,
        ST_DONE,
        ST_ERROR
    } seq_state_t;

    typedef enum logic [2:0] {
        STAT_IDLE    = 3'd0,
        STAT_LOADING = 3'd1,
        STAT_WAITING = 3'd2,
        STAT_DONE    = 3'd3,
        STAT_ERROR   = 3'd4
    } stat_code_t;

    function automatic stat_code_t stat_of(seq_state_t s);
        stat_code_t c;
        unique case (s)
            ST_IDLE:                      c = STAT_IDLE;
            ST_FETCH, ST_STROBE, ST_GAP:  c = STAT_LOADING;
            ST_WAIT:                      c = STAT_WAITING;
            ST_DONE:                      c = STAT_DONE;
            ST_ERROR:                     c = STAT_ERROR;
            default:                      c = STAT_IDLE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sh;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= RST_VAL;
                else        sh <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= {STAGES{RST_VAL}};
                else        sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
    import cfg_loader_pkg::*;
#(
    parameter int DW        = 8,
    parameter int CNT_W     = 16,
    parameter int STRB_LOW  = 4,
    parameter int STRB_HIGH = 2,
    parameter int DONE_WAIT = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    input  logic             done_s,
    output logic [DW-1:0]    cfg_d,
    output logic             cfg_wr_n,
    output seq_state_t       state_o,
    output logic [CNT_W-1:0] byte_cnt,
    output logic             load_err
);

    localparam int MAX_A  = (STRB_LOW > STRB_HIGH) ? STRB_LOW : STRB_HIGH;
    localparam int MAX_T  = (MAX_A > DONE_WAIT) ? MAX_A : DONE_WAIT;
    localparam int TMR_W  = $clog2(MAX_T + 1);
    localparam logic [TMR_W-1:0] LOW_END  = TMR_W'(STRB_LOW - 1);
    localparam logic [TMR_W-1:0] HIGH_END = TMR_W'(STRB_HIGH - 1);
    localparam logic [TMR_W-1:0] WAIT_END = TMR_W'(DONE_WAIT - 1);

    seq_state_t       state, nxt;
    logic [TMR_W-1:0] tmr;
    logic             tmr_clr, accept, cnt_clr, last_q;

    // next-state decision
    always_comb begin
        nxt     = state;
        tmr_clr = 1'b0;
        accept  = 1'b0;
        cnt_clr = 1'b0;
        unique case (state)
            ST_IDLE, ST_DONE, ST_ERROR: begin
                if (start) begin
                    nxt     = ST_FETCH;
                    cnt_clr = 1'b1;
                end
            end
            ST_FETCH: begin
                if (s_valid) begin
                    nxt     = ST_STROBE;
                    accept  = 1'b1;
                    tmr_clr = 1'b1;
                end
            end
            ST_STROBE: begin
                if (tmr == LOW_END) begin
                    nxt     = ST_GAP;
                    tmr_clr = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr == HIGH_END) begin
                    nxt     = last_q ? ST_WAIT : ST_FETCH;
                    tmr_clr = 1'b1;
                end
            end
            ST_WAIT: begin
                if (done_s)                nxt = ST_DONE;
                else if (tmr == WAIT_END)  nxt = ST_ERROR;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr      <= '0;
            byte_cnt <= '0;
            cfg_d    <= '0;
            last_q   <= 1'b0;
        end else begin
            tmr <= tmr_clr ? '0 : tmr + 1'b1;
            if (cnt_clr)     byte_cnt <= '0;
            else if (accept) byte_cnt <= byte_cnt + 1'b1;
            if (accept) begin
                cfg_d  <= s_data;
                last_q <= s_last;
            end
        end
    end

    // outputs
    always_comb begin
        s_ready  = (state == ST_FETCH);
        cfg_wr_n = (state != ST_STROBE);
        load_err = (state == ST_ERROR);
        state_o  = state;
    end

    p_accept_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !cfg_wr_n);

    p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> (byte_cnt == $past(byte_cnt) + 1'b1));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STROBE || state == ST_GAP || state == ST_WAIT) && start)
        |=> (byte_cnt == $past(byte_cnt)));

    p_err_from_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_err) |-> ($past(state) == ST_WAIT));

    p_high_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_wr_n) |=> cfg_wr_n);

    generate
        if (STRB_LOW >= 2) begin : g_low_chk
            p_low_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(cfg_wr_n) |=> (!cfg_wr_n && $stable(cfg_d)));
        end
    endgenerate

endmodule

// File: rtl/cfg_pin_route.sv
module cfg_pin_route (
    input  logic loaded,
    input  logic irq_n_s,
    input  logic dreq_s,
    output logic run_irq,
    output logic run_dreq
);

    always_comb begin
        run_irq  = loaded & ~irq_n_s;
        run_dreq = loaded & dreq_s;
    end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int DW          = 8,
    parameter int CNT_W       = 16,
    parameter int STRB_LOW    = 4,
    parameter int STRB_HIGH   = 2,
    parameter int DONE_WAIT   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic [DW-1:0]    cfg_d,
    output logic             cfg_wr_n,
    input  logic             done_irq_n,
    input  logic             dreq_line,
    output logic             run_irq,
    output logic             run_dreq,
    output logic [2:0]       stat_code,
    output logic [CNT_W-1:0] stat_count,
    output logic             load_err
);

    logic       line_a_s, line_b_s;
    seq_state_t seq_state;
    stat_code_t code;

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .d(done_irq_n), .q(line_a_s));

    cfg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .d(dreq_line), .q(line_b_s));

    cfg_seq_fsm #(
        .DW(DW), .CNT_W(CNT_W), .STRB_LOW(STRB_LOW),
        .STRB_HIGH(STRB_HIGH), .DONE_WAIT(DONE_WAIT)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .done_s(line_a_s), .cfg_d(cfg_d), .cfg_wr_n(cfg_wr_n),
        .state_o(seq_state), .byte_cnt(stat_count), .load_err(load_err));

    assign code      = stat_of(seq_state);
    assign stat_code = code;

    cfg_pin_route u_route (
        .loaded(code == STAT_DONE), .irq_n_s(line_a_s), .dreq_s(line_b_s),
        .run_irq(run_irq), .run_dreq(run_dreq));

    p_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (code != STAT_DONE) |-> (!run_irq && !run_dreq));

    p_strobe_in_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_n |-> (stat_code == 3'd1));

endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;

    localparam int DW = 8, CNT_W = 8, L = 3, H = 2, W = 20;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [DW-1:0] s_data = '0;
    logic s_valid = 1'b0, s_last = 1'b0;
    logic done_irq_n = 1'b0, dreq_line = 1'b0;
    logic s_ready, cfg_wr_n, run_irq, run_dreq, load_err;
    logic [DW-1:0] cfg_d;
    logic [2:0] stat_code;
    logic [CNT_W-1:0] stat_count;

    int checks = 0, errors = 0, cycles = 0;
    bit started = 1'b0;

    always #10 clk = ~clk;

    cfg_loader #(.DW(DW), .CNT_W(CNT_W), .STRB_LOW(L), .STRB_HIGH(H),
                 .DONE_WAIT(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data),
        .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .cfg_d(cfg_d), .cfg_wr_n(cfg_wr_n), .done_irq_n(done_irq_n),
        .dreq_line(dreq_line), .run_irq(run_irq), .run_dreq(run_dreq),
        .stat_code(stat_code), .stat_count(stat_count), .load_err(load_err));

    // behavioural reference: 0 idle 1 fetch 2 low 3 high 4 wait 5 done 6 error
    int m_mode, m_tmr, m_cnt, m_data;
    bit m_last, m_busy_start;
    bit ha1, ha2, hb1, hb2;

    always @(posedge clk) begin
        started = 1'b1;
        if (!rst_n) begin
            m_mode = 0; m_tmr = 0; m_cnt = 0; m_data = 0; m_last = 0;
            m_busy_start = 0;
            ha1 = 1; ha2 = 1; hb1 = 0; hb2 = 0;
        end else begin
            m_busy_start = start && (m_mode >= 1 && m_mode <= 4);
            case (m_mode)
                0, 5, 6: if (start) begin m_mode = 1; m_cnt = 0; end
                1: if (s_valid) begin
                       m_data = int'(s_data); m_last = s_last;
                       m_cnt = (m_cnt + 1) % (1 << CNT_W); m_mode = 2; m_tmr = 0;
                   end
                2: if (m_tmr == L - 1) begin m_mode = 3; m_tmr = 0; end
                   else m_tmr++;
                3: if (m_tmr == H - 1) begin m_mode = m_last ? 4 : 1; m_tmr = 0; end
                   else m_tmr++;
                4: if (ha2) m_mode = 5;
                   else if (m_tmr == W - 1) m_mode = 6;
                   else m_tmr++;
                default: m_mode = 0;
            endcase
            ha2 = ha1; ha1 = done_irq_n;
            hb2 = hb1; hb1 = dreq_line;
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     tag, what, act, exp, cycles);
        end
    endtask

    function automatic int code_of(int m);
        case (m)
            0: return 0;
            1, 2, 3: return 1;
            4: return 2;
            5: return 3;
            default: return 4;
        endcase
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        if (started) begin
            if (!rst_n) begin
                chk("R1", int'(stat_code), 0, "reset code");
                chk("R1", int'(cfg_wr_n), 1, "reset strobe");
                chk("R1", int'(s_ready), 0, "reset ready");
                chk("R1", int'(stat_count), 0, "reset count");
                chk("R1", int'({load_err, run_irq, run_dreq}), 0, "reset flags");
            end else begin
                chk(m_mode == 5 ? "R6" : (m_mode == 6 ? "R7" : "R10"),
                    int'(stat_code), code_of(m_mode), "status code");
                chk("R4/R5", int'(cfg_wr_n), (m_mode == 2) ? 0 : 1, "strobe");
                chk("R3", int'(s_ready), (m_mode == 1) ? 1 : 0, "ready");
                chk(m_busy_start ? "R9" : "R2/R3", int'(stat_count), m_cnt, "count");
                if (m_mode == 2) chk("R4", int'(cfg_d), m_data, "data");
                chk("R7", int'(load_err), (m_mode == 6) ? 1 : 0, "error flag");
                chk("R8", int'(run_irq), (m_mode == 5 && !ha2) ? 1 : 0, "run irq");
                chk("R8", int'(run_dreq), (m_mode == 5 && hb2) ? 1 : 0, "run dreq");
            end
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic pulse_start();
        start = 1'b1; step(1); start = 1'b0;
    endtask

    // send n bytes; gap idle cycles before each; start raised during byte sbyte (R9)
    task automatic send(int n, int base, int gap, int sbyte);
        for (int i = 0; i < n; i++) begin
            bit got;
            s_valid = 1'b0;
            step(gap);
            s_valid = 1'b1;
            s_data  = DW'(base + i * 37);
            s_last  = (i == n - 1);
            start   = (i == sbyte);
            got = 1'b0;
            while (!got) begin
                @(negedge clk); got = s_ready;
                @(posedge clk); #2;
                start = 1'b0;
            end
        end
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(3);
        // R2/R3: first load, continuous stream, start during load (R9)
        pulse_start();
        dreq_line = 1'b1;               // gated while loading (R8)
        send(5, 8'h11, 0, 2);
        step(2);
        pulse_start();                  // during wait, ignored (R9)
        step(2);
        done_irq_n = 1'b1;              // R6 completion after last byte
        step(8);
        done_irq_n = 1'b0; step(3);     // R8 interrupt asserted
        done_irq_n = 1'b1; dreq_line = 1'b0; step(3);
        dreq_line = 1'b1; step(2);
        // resume reload with gaps; completion never comes: R7
        done_irq_n = 1'b0; dreq_line = 1'b0;
        pulse_start();
        send(3, 8'hA0, 2, -1);
        step(W + 6);
        dreq_line = 1'b1; done_irq_n = 1'b0; step(3);   // gated in error (R8)
        // restart from error: R2
        dreq_line = 1'b0;
        pulse_start();
        done_irq_n = 1'b1;              // high while loading must not end load (R6)
        send(4, 8'h5C, 1, 1);
        step(12);
        // reload from done with line held high
        pulse_start();
        send(2, 8'hF0, 0, -1);
        step(12);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule